// File: doc/BRIEF.md
# Prioritized CPU Interrupt Controller

This block is the interrupt unit of a small 8-bit processor core. Two small registers are reachable over a byte-wide register bus: a per-source enable mask and a per-source pending-flag register. Five peripheral sources raise single-cycle request pulses, and each pulse latches a flag bit. Inside the block sit a master enable, a one-instruction deferred-enable flag and a halt state. The instruction decoder drives the master-enable commands and the halt command.

The decoder marks each instruction boundary with a one-cycle `insn_done` pulse, before the next opcode fetch. At that point the controller may start a dispatch. A dispatch is a fixed five-cycle sequence:

- two idle cycles;
- a strobe to push the high byte of the return address;
- a strobe to push the low byte;
- a vector-load cycle that presents the service address.

While the core is halted, any enabled pending request releases it. If the master enable is off, the core simply resumes and no dispatch follows.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the master enable, halt state, `wake`, `busy` and all strobes are low. Both registers read 0xE0: upper three bits are 1 and the enable and flag fields are cleared.
- R2: Writing address 0xFFFF stores bits 4:0 into the enable register, and writing 0xFF0F stores bits 4:0 into the flag register. Reads of either return the stored bits with bits 7:5 forced to 1. Any other address reads 0x00, and writes to it change neither register.
- R3: A pulse on `src_req[n]` sets flag bit n on the next clock edge. When it coincides with a flag-register write, the request wins for that bit and the written value applies to the other bits.
- R4: A dispatch starts at a boundary only if the effective master enable is on and (enable AND flag) is nonzero. The lowest-numbered pending bit wins, and its vector is 0x0040 + 8·n (0x40, 0x48, 0x50, 0x58, 0x60).
- R5: A dispatch starting at a boundary drives `busy` high for exactly five cycles, beginning in the cycle after the boundary. `push_hi` is high in the third cycle, `push_lo` in the fourth, and `vec_load` with `vec_addr` in the fifth; each strobe is high for one cycle only.
- R6: A dispatch clears the master enable and clears only the winning flag bit. Other flag bits stay set.
- R7: A disable command at a boundary blocks a dispatch at that same boundary, and the master enable reads low from the next cycle.
- R8: An enable command never allows a dispatch at its own boundary. The master enable turns on at the next boundary, where a dispatch is already allowed.
- R9: A disable command at the boundary that follows an enable cancels the deferred enable. The master enable stays low and later boundaries do not dispatch.
- R10: A halt command at a boundary raises `halted`. While halted, a nonzero pending value clears `halted` one edge after the flag is seen. With the master enable off, `wake` pulses for one cycle, no dispatch follows and the flag bit stays set.
- R11: While halted with the master enable on, a pending request clears `halted` and starts a dispatch on the same edge.
- R12: `insn_done` and its commands are ignored while `busy` or `halted` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 16 | Register bus address |
| reg_wr | input | 1 | Register bus write strobe |
| reg_wdata | input | 8 | Register bus write data |
| reg_rdata | output | 8 | Register bus read data (combinational on `reg_addr`) |
| src_req | input | 5 | One-cycle request pulses; bit 0 frame-blank, 1 display status, 2 timer, 3 serial, 4 keypad |
| insn_done | input | 1 | Instruction boundary pulse from the decoder |
| cmd_di | input | 1 | Disable command, qualified by `insn_done` |
| cmd_ei | input | 1 | Deferred enable command, qualified by `insn_done` |
| cmd_halt | input | 1 | Halt command, qualified by `insn_done` |
| ime | output | 1 | Master enable state |
| halted | output | 1 | Core is halted |
| wake | output | 1 | One-cycle pulse when halt ends without a dispatch |
| busy | output | 1 | Dispatch sequence in progress |
| push_hi | output | 1 | Push the high byte of the return address |
| push_lo | output | 1 | Push the low byte of the return address |
| vec_load | output | 1 | Load the program counter from `vec_addr` |
| vec_addr | output | 16 | Service vector, valid with `vec_load`, else zero |

## Verification
A corrupted winner latch shows up five cycles after the boundary, as a wrong `vec_addr` on `vec_load`. A wrong acknowledge mask shows up on the next flag read, as extra bits cleared or the winner left set. A stuck deferred-enable flag shows up at the very next boundary, as a dispatch that should not happen or one that is missing. A broken halt state shows one edge after the flag is set, in `halted`, `wake` or `busy`. The sequencing strobes are compared cycle by cycle, so an off-by-one in the idle counter is caught at the first dispatch.

// File: rtl/irq_pkg.sv
package irq_pkg;

   typedef enum logic [2:0] {
      SEQ_IDLE    = 3'd0,
      SEQ_WAIT    = 3'd1,
      SEQ_PUSH_HI = 3'd2,
      SEQ_PUSH_LO = 3'd3,
      SEQ_LOAD    = 3'd4
   } seq_state_t;

   function automatic int unsigned idx_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/irq_regfile.sv
module irq_regfile #(
   parameter int unsigned NUM_SRC = 5,
   parameter int unsigned ADDR_W  = 16,
   parameter int unsigned DATA_W  = 8,
   parameter logic [ADDR_W-1:0] EN_ADDR   = 16'hFFFF,
   parameter logic [ADDR_W-1:0] FLAG_ADDR = 16'hFF0F
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic               reg_wr,
   input  logic [DATA_W-1:0]  reg_wdata,
   output logic [DATA_W-1:0]  reg_rdata,
   input  logic [NUM_SRC-1:0] src_req,
   input  logic [NUM_SRC-1:0] ack_clr,
   output logic [NUM_SRC-1:0] en_q,
   output logic [NUM_SRC-1:0] flag_q
);
   localparam int unsigned PAD_W = DATA_W - NUM_SRC;

   if (NUM_SRC > DATA_W) begin : g_bad_width
      $error("irq_regfile: NUM_SRC must not exceed DATA_W");
   end

   logic hit_en;
   logic hit_flag;
   logic wr_en;
   logic wr_flag;

   assign hit_en   = (reg_addr == EN_ADDR);
   assign hit_flag = (reg_addr == FLAG_ADDR);
   assign wr_en    = reg_wr & hit_en;
   assign wr_flag  = reg_wr & hit_flag;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q <= '0;
      end else if (wr_en) begin
         en_q <= reg_wdata[NUM_SRC-1:0];
      end
   end

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            flag_q[i] <= 1'b0;
         end else if (src_req[i]) begin
            flag_q[i] <= 1'b1;
         end else if (ack_clr[i]) begin
            flag_q[i] <= 1'b0;
         end else if (wr_flag) begin
            flag_q[i] <= reg_wdata[i];
         end
      end
   end

   logic [NUM_SRC-1:0] sel_field;
   always_comb begin
      sel_field = '0;
      if (hit_en) begin
         sel_field = en_q;
      end else if (hit_flag) begin
         sel_field = flag_q;
      end
   end

   if (PAD_W > 0) begin : g_padded
      assign reg_rdata = (hit_en || hit_flag) ? {{PAD_W{1'b1}}, sel_field} : '0;
   end else begin : g_full
      assign reg_rdata = sel_field;
   end

   p_req_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (|src_req) |=> ((flag_q & $past(src_req)) == $past(src_req)))
      else $error("request pulse did not latch its flag");

   p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ((|ack_clr) && !(|(ack_clr & src_req))) |=> ((flag_q & $past(ack_clr)) == '0))
      else $error("acknowledged flag still set");

   p_foreign_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && !hit_en && !hit_flag) |=> (en_q == $past(en_q)))
      else $error("write to foreign address changed enable mask");

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
   parameter int unsigned NUM_SRC = 5,
   parameter int unsigned IDX_W   = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] en_q,
   input  logic [NUM_SRC-1:0] flag_q,
   output logic               any_pend,
   output logic [NUM_SRC-1:0] grant,
   output logic [IDX_W-1:0]   win_idx
);
   logic [NUM_SRC-1:0] pend;
   logic [NUM_SRC:0]   blocked;

   assign pend       = en_q & flag_q;
   assign any_pend   = |pend;
   assign blocked[0] = 1'b0;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_chain
      assign grant[i]     = pend[i] & ~blocked[i];
      assign blocked[i+1] = blocked[i] | pend[i];
   end

   always_comb begin
      win_idx = '0;
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
         if (grant[i]) begin
            win_idx = IDX_W'(i);
         end
      end
   end

   p_grant_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant) && ((grant & ~pend) == '0) && (any_pend == (|grant)))
      else $error("grant not a single pending source");

endmodule

// File: rtl/irq_sequencer.sv
module irq_sequencer
   import irq_pkg::*;
#(
   parameter int unsigned NUM_SRC  = 5,
   parameter int unsigned IDX_W    = 3,
   parameter int unsigned ADDR_W   = 16,
   parameter logic [ADDR_W-1:0] VEC_BASE = 16'h0040,
   parameter int unsigned VEC_STEP = 8,
   parameter int unsigned IDLE_CYC = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               insn_done,
   input  logic               cmd_di,
   input  logic               cmd_ei,
   input  logic               cmd_halt,
   input  logic               any_pend,
   input  logic [NUM_SRC-1:0] grant,
   input  logic [IDX_W-1:0]   win_idx,
   output logic [NUM_SRC-1:0] ack_clr,
   output logic               ime,
   output logic               halted,
   output logic               wake,
   output logic               busy,
   output logic               push_hi,
   output logic               push_lo,
   output logic               vec_load,
   output logic [ADDR_W-1:0]  vec_addr
);
   localparam int unsigned CNT_W = (IDLE_CYC > 1) ? $clog2(IDLE_CYC) : 1;
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(IDLE_CYC - 1);

   if (IDLE_CYC < 1) begin : g_bad_idle
      $error("irq_sequencer: IDLE_CYC must be at least 1");
   end

   seq_state_t       state_q;
   logic [CNT_W-1:0] cnt_q;
   logic [IDX_W-1:0] win_q;
   logic             ime_q;
   logic             ei_pend_q;
   logic             halted_q;
   logic             wake_q;

   logic bnd;
   logic ime_eff;
   logic take_bnd;
   logic take_halt;
   logic take;

   assign bnd       = insn_done && (state_q == SEQ_IDLE) && !halted_q;
   assign ime_eff   = !cmd_di && (ime_q || ei_pend_q);
   assign take_bnd  = bnd && ime_eff && any_pend;
   assign take_halt = halted_q && ime_q && any_pend;
   assign take      = take_bnd || take_halt;
   assign ack_clr   = take ? grant : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= SEQ_IDLE;
         cnt_q     <= '0;
         win_q     <= '0;
         ime_q     <= 1'b0;
         ei_pend_q <= 1'b0;
         halted_q  <= 1'b0;
         wake_q    <= 1'b0;
      end else begin
         wake_q <= halted_q && any_pend && !ime_q;

         if (halted_q && any_pend) begin
            halted_q <= 1'b0;
         end

         if (bnd && !take) begin
            if (cmd_di) begin
               ime_q     <= 1'b0;
               ei_pend_q <= 1'b0;
            end else begin
               if (ei_pend_q) begin
                  ime_q <= 1'b1;
               end
               ei_pend_q <= cmd_ei;
            end
            if (cmd_halt) begin
               halted_q <= 1'b1;
            end
         end

         case (state_q)
            SEQ_IDLE: begin
               if (take) begin
                  ime_q     <= 1'b0;
                  ei_pend_q <= 1'b0;
                  win_q     <= win_idx;
                  cnt_q     <= '0;
                  state_q   <= SEQ_WAIT;
               end
            end
            SEQ_WAIT: begin
               if (cnt_q == CNT_LAST) begin
                  state_q <= SEQ_PUSH_HI;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            SEQ_PUSH_HI: state_q <= SEQ_PUSH_LO;
            SEQ_PUSH_LO: state_q <= SEQ_LOAD;
            SEQ_LOAD:    state_q <= SEQ_IDLE;
            default:     state_q <= SEQ_IDLE;
         endcase
      end
   end

   assign ime      = ime_q;
   assign halted   = halted_q;
   assign wake     = wake_q;
   assign busy     = (state_q != SEQ_IDLE);
   assign push_hi  = (state_q == SEQ_PUSH_HI);
   assign push_lo  = (state_q == SEQ_PUSH_LO);
   assign vec_load = (state_q == SEQ_LOAD);
   assign vec_addr = vec_load ? (VEC_BASE + ADDR_W'(win_q) * ADDR_W'(VEC_STEP)) : '0;

   p_strobe_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({push_hi, push_lo, vec_load}))
      else $error("more than one dispatch strobe");

   p_lo_after_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
      push_hi |=> push_lo)
      else $error("low push did not follow high push");

   p_load_after_lo_r5: assert property (@(posedge clk) disable iff (!rst_n)
      push_lo |=> vec_load)
      else $error("vector load did not follow low push");

   p_ime_low_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !ime)
      else $error("master enable high during dispatch");

   p_di_immediate_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (insn_done && cmd_di && !busy && !halted) |=> (!ime && !busy))
      else $error("disable command did not take effect at once");

   p_ei_deferred_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (insn_done && cmd_ei && !cmd_di && !ime && !ei_pend_q && !busy && !halted) |=> !busy)
      else $error("dispatch at the enable command's own boundary");

   p_halt_not_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(halted && busy))
      else $error("halted while dispatching");

   p_wake_no_dispatch_r10: assert property (@(posedge clk) disable iff (!rst_n)
      wake |-> (!busy && !halted))
      else $error("wake pulse with dispatch or halt");

   p_ignore_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && insn_done && cmd_halt) |=> !halted)
      else $error("halt command accepted during dispatch");

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
   import irq_pkg::*;
#(
   parameter int unsigned NUM_SRC  = 5,
   parameter int unsigned ADDR_W   = 16,
   parameter int unsigned DATA_W   = 8,
   parameter logic [ADDR_W-1:0] EN_ADDR   = 16'hFFFF,
   parameter logic [ADDR_W-1:0] FLAG_ADDR = 16'hFF0F,
   parameter logic [ADDR_W-1:0] VEC_BASE  = 16'h0040,
   parameter int unsigned VEC_STEP = 8,
   parameter int unsigned IDLE_CYC = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic               reg_wr,
   input  logic [DATA_W-1:0]  reg_wdata,
   output logic [DATA_W-1:0]  reg_rdata,
   input  logic [NUM_SRC-1:0] src_req,
   input  logic               insn_done,
   input  logic               cmd_di,
   input  logic               cmd_ei,
   input  logic               cmd_halt,
   output logic               ime,
   output logic               halted,
   output logic               wake,
   output logic               busy,
   output logic               push_hi,
   output logic               push_lo,
   output logic               vec_load,
   output logic [ADDR_W-1:0]  vec_addr
);
   localparam int unsigned IDX_W = idx_width(NUM_SRC);

   if (NUM_SRC < 1) begin : g_bad_src
      $error("irq_prio_ctrl: NUM_SRC must be at least 1");
   end
   if (EN_ADDR == FLAG_ADDR) begin : g_bad_map
      $error("irq_prio_ctrl: register addresses must differ");
   end

   logic [NUM_SRC-1:0] en_q;
   logic [NUM_SRC-1:0] flag_q;
   logic [NUM_SRC-1:0] ack_clr;
   logic [NUM_SRC-1:0] grant;
   logic [IDX_W-1:0]   win_idx;
   logic               any_pend;

   irq_regfile #(
      .NUM_SRC  (NUM_SRC),
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .EN_ADDR  (EN_ADDR),
      .FLAG_ADDR(FLAG_ADDR)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .reg_addr (reg_addr),
      .reg_wr   (reg_wr),
      .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata),
      .src_req  (src_req),
      .ack_clr  (ack_clr),
      .en_q     (en_q),
      .flag_q   (flag_q)
   );

   irq_arbiter #(
      .NUM_SRC(NUM_SRC),
      .IDX_W  (IDX_W)
   ) u_arb (
      .clk     (clk),
      .rst_n   (rst_n),
      .en_q    (en_q),
      .flag_q  (flag_q),
      .any_pend(any_pend),
      .grant   (grant),
      .win_idx (win_idx)
   );

   irq_sequencer #(
      .NUM_SRC (NUM_SRC),
      .IDX_W   (IDX_W),
      .ADDR_W  (ADDR_W),
      .VEC_BASE(VEC_BASE),
      .VEC_STEP(VEC_STEP),
      .IDLE_CYC(IDLE_CYC)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .insn_done(insn_done),
      .cmd_di   (cmd_di),
      .cmd_ei   (cmd_ei),
      .cmd_halt (cmd_halt),
      .any_pend (any_pend),
      .grant    (grant),
      .win_idx  (win_idx),
      .ack_clr  (ack_clr),
      .ime      (ime),
      .halted   (halted),
      .wake     (wake),
      .busy     (busy),
      .push_hi  (push_hi),
      .push_lo  (push_lo),
      .vec_load (vec_load),
      .vec_addr (vec_addr)
   );

   p_vec_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
      vec_load |-> ((vec_addr >= VEC_BASE) && (vec_addr < VEC_BASE + ADDR_W'(NUM_SRC * VEC_STEP))))
      else $error("vector outside the service table");

endmodule

// File: tb/irq_prio_ctrl_test.sv
module irq_prio_ctrl_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] reg_addr = '0;
   logic        reg_wr = 1'b0;
   logic [7:0]  reg_wdata = '0;
   logic [7:0]  reg_rdata;
   logic [4:0]  src_req = '0;
   logic        insn_done = 1'b0;
   logic        cmd_di = 1'b0;
   logic        cmd_ei = 1'b0;
   logic        cmd_halt = 1'b0;
   logic        ime, halted, wake, busy, push_hi, push_lo, vec_load;
   logic [15:0] vec_addr;

   int compared = 0;
   int mismatched = 0;
   logic [15:0] exp_q[$];

   always #2 clk = ~clk;

   irq_prio_ctrl uut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_req(src_req),
      .insn_done(insn_done), .cmd_di(cmd_di), .cmd_ei(cmd_ei), .cmd_halt(cmd_halt),
      .ime(ime), .halted(halted), .wake(wake), .busy(busy), .push_hi(push_hi),
      .push_lo(push_lo), .vec_load(vec_load), .vec_addr(vec_addr)
   );

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   // monitor: every vector load is compared with the next queued expectation
   always @(negedge clk) begin
      if (rst_n && vec_load) begin
         if (exp_q.size() == 0) begin
            chk("R4 unexpected vector", vec_addr, 16'hFFFF);
         end else begin
            chk("R4 vector", vec_addr, exp_q.pop_front());
         end
      end
   end

   task automatic expect_vec(input logic [15:0] v);
      exp_q.push_back(v);
   endtask

   task automatic wr(input logic [15:0] a, input logic [7:0] d);
      @(posedge clk); #1;
      reg_addr = a; reg_wr = 1'b1; reg_wdata = d;
      @(posedge clk); #1;
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [15:0] a, output logic [7:0] d);
      @(posedge clk); #1;
      reg_addr = a;
      @(negedge clk);
      d = reg_rdata;
   endtask

   task automatic bnd(input logic di, input logic ei, input logic ht);
      @(posedge clk); #1;
      insn_done = 1'b1; cmd_di = di; cmd_ei = ei; cmd_halt = ht;
      @(posedge clk); #1;
      insn_done = 1'b0; cmd_di = 1'b0; cmd_ei = 1'b0; cmd_halt = 1'b0;
   endtask

   task automatic req(input logic [4:0] m);
      @(posedge clk); #1;
      src_req = m;
      @(posedge clk); #1;
      src_req = '0;
   endtask

   // R5: five busy cycles after the boundary, strobes in cycles 3, 4, 5
   task automatic check_seq();
      for (int k = 1; k <= 5; k++) begin
         @(negedge clk);
         chk("R5 busy", 16'(busy), 16'd1);
         chk("R5 push_hi", 16'(push_hi), 16'(k == 3));
         chk("R5 push_lo", 16'(push_lo), 16'(k == 4));
         chk("R5 vec_load", 16'(vec_load), 16'(k == 5));
      end
      @(negedge clk);
      chk("R5 busy end", 16'(busy), 16'd0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      mismatched++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      logic [7:0] d;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      @(negedge clk);
      chk("R1 ime", 16'(ime), 16'd0);
      chk("R1 halted", 16'(halted), 16'd0);
      chk("R1 busy", 16'(busy), 16'd0);
      chk("R1 wake", 16'(wake), 16'd0);
      rd(16'hFFFF, d); chk("R1 enable read", 16'(d), 16'h00E0);
      rd(16'hFF0F, d); chk("R1 flag read", 16'(d), 16'h00E0);

      // R2 register bus
      wr(16'hFFFF, 8'h1F); rd(16'hFFFF, d); chk("R2 enable", 16'(d), 16'h00FF);
      wr(16'hFF0F, 8'h0A); rd(16'hFF0F, d); chk("R2 flag", 16'(d), 16'h00EA);
      wr(16'h1234, 8'h00); rd(16'h1234, d); chk("R2 foreign read", 16'(d), 16'h0000);
      rd(16'hFFFF, d); chk("R2 foreign write enable", 16'(d), 16'h00FF);
      rd(16'hFF0F, d); chk("R2 foreign write flag", 16'(d), 16'h00EA);
      wr(16'hFF0F, 8'h00);

      // R3 request latch and request-beats-write
      req(5'b00100); rd(16'hFF0F, d); chk("R3 request sets", 16'(d), 16'h00E4);
      @(posedge clk); #1;
      reg_addr = 16'hFF0F; reg_wr = 1'b1; reg_wdata = 8'h00; src_req = 5'b00010;
      @(posedge clk); #1;
      reg_wr = 1'b0; src_req = '0;
      rd(16'hFF0F, d); chk("R3 request wins", 16'(d), 16'h00E2);
      wr(16'hFF0F, 8'h00);

      // R4 no dispatch with master enable off
      wr(16'hFF0F, 8'h01); bnd(0, 0, 0);
      @(negedge clk); chk("R4 ime off no dispatch", 16'(busy), 16'd0);
      wr(16'hFF0F, 8'h00);

      // R4 enable mask gates pending; R8 ime turns on one boundary later
      wr(16'hFFFF, 8'h04); wr(16'hFF0F, 8'h03);
      bnd(0, 1, 0);
      @(negedge clk); chk("R8 ime still off", 16'(ime), 16'd0);
      bnd(0, 0, 0);
      @(negedge clk); chk("R4 masked no dispatch", 16'(busy), 16'd0);
      chk("R8 ime on after next boundary", 16'(ime), 16'd1);
      bnd(1, 0, 0);
      @(negedge clk); chk("R7 ime off", 16'(ime), 16'd0);
      wr(16'hFF0F, 8'h00); wr(16'hFFFF, 8'h1F);

      // R7 disable at a boundary with pending and ime on blocks dispatch
      bnd(0, 1, 0); bnd(0, 0, 0);
      wr(16'hFF0F, 8'h08);
      @(negedge clk); chk("R7 no dispatch between boundaries", 16'(busy), 16'd0);
      bnd(1, 0, 0);
      @(negedge clk);
      chk("R7 no dispatch at disable", 16'(busy), 16'd0);
      chk("R7 ime cleared", 16'(ime), 16'd0);
      rd(16'hFF0F, d); chk("R7 flag kept", 16'(d), 16'h00E8);
      wr(16'hFF0F, 8'h00);

      // R9 disable after enable cancels it
      bnd(0, 1, 0); bnd(1, 0, 0);
      @(negedge clk); chk("R9 ime stays off", 16'(ime), 16'd0);
      wr(16'hFF0F, 8'h01); bnd(0, 0, 0);
      @(negedge clk);
      chk("R9 no dispatch", 16'(busy), 16'd0);
      chk("R9 ime off", 16'(ime), 16'd0);
      wr(16'hFF0F, 8'h00);

      // R4 R5 R6 R8 priority walk over all vectors
      wr(16'hFF0F, 8'h1F);
      for (int n = 0; n < 5; n++) begin
         expect_vec(16'h0040 + 16'(8 * n));
         bnd(0, 1, 0);
         @(negedge clk); chk("R8 no dispatch at enable", 16'(busy), 16'd0);
         bnd(0, 0, 0);
         check_seq();
         chk("R6 ime cleared", 16'(ime), 16'd0);
         rd(16'hFF0F, d);
         chk("R6 only winner cleared", 16'(d), 16'(8'hE0 | (8'h1F & ~((8'd2 << n) - 8'd1))));
      end

      // R10 halt with ime off: wake, no dispatch, flag kept
      bnd(0, 0, 1);
      @(negedge clk); chk("R10 halted", 16'(halted), 16'd1);
      bnd(0, 1, 0);
      @(negedge clk); chk("R12 boundary ignored while halted", 16'(halted), 16'd1);
      req(5'b01000);
      @(negedge clk); chk("R10 still halted", 16'(halted), 16'd1);
      @(negedge clk);
      chk("R10 released", 16'(halted), 16'd0);
      chk("R10 wake", 16'(wake), 16'd1);
      chk("R10 no dispatch", 16'(busy), 16'd0);
      @(negedge clk);
      chk("R10 wake one cycle", 16'(wake), 16'd0);
      chk("R10 ime off", 16'(ime), 16'd0);
      rd(16'hFF0F, d); chk("R10 flag kept", 16'(d), 16'h00E8);
      wr(16'hFF0F, 8'h00);

      // R11 halt with ime on dispatches; R12 commands ignored while busy
      bnd(0, 1, 0); bnd(0, 0, 0);
      bnd(0, 0, 1);
      @(negedge clk); chk("R11 halted", 16'(halted), 16'd1);
      expect_vec(16'h0048);
      req(5'b00010);
      @(negedge clk); chk("R11 still halted", 16'(halted), 16'd1);
      @(negedge clk);
      chk("R11 released", 16'(halted), 16'd0);
      chk("R11 dispatching", 16'(busy), 16'd1);
      chk("R11 no wake", 16'(wake), 16'd0);
      @(posedge clk); #1;
      insn_done = 1'b1; cmd_halt = 1'b1;
      @(posedge clk); #1;
      insn_done = 1'b0; cmd_halt = 1'b0;
      while (busy) @(negedge clk);
      @(negedge clk);
      chk("R12 halt ignored while busy", 16'(halted), 16'd0);
      rd(16'hFF0F, d); chk("R11 flag acknowledged", 16'(d), 16'h00E0);

      repeat (3) @(negedge clk);
      chk("R4 all vectors seen", 16'(exp_q.size()), 16'd0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule